// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

An eight-pin I/O port whose pins a processor configures one at a time. Each pin can drive a value or read one. It can also watch its input for a level or an edge and raise an interrupt request. The pad is modelled as three separate signals: an input, an output value and an output enable. Every pin has its own request line, and a combined request is also provided for an interrupt controller.

Pin inputs pass through a two-flop synchroniser on the system clock. In level mode the pin's own data bit selects the active level. A request is raised only after the synchronised pin has matched that level on two consecutive clocks. It drops as soon as the pin stops matching. In edge mode the data bit selects the active edge. A detected edge sets a sticky flag, and software clears the flag by writing 1 to its bit.

Software uses a simple register port: a single-cycle write strobe with address and data, and a combinational read of the register selected by a read address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every pin is in input mode (mode code 2'b01, so both mode registers read 8'h55), the data register and edge flags read 0, all output enables are 0 and no request is active.
- R2: Mode codes per pin are 2'b00 output, 2'b01 input, 2'b10 level interrupt and 2'b11 edge interrupt. The output enable of a pin is 1 only in output mode, and in that mode the pin output carries its data bit.
- R3: The input register returns the pin values delayed by two clocks through the synchroniser, whatever mode each pin is in.
- R4: A pin in level mode raises its request once two consecutive synchronised samples equal its data bit. A pin change made between clock edges shows on the request after the fourth edge.
- R5: A matching pulse that is seen by only one synchronised sample raises no request.
- R6: A level request stays active while the pin keeps matching and falls after the third edge following a pin change away from the active level.
- R7: In level mode a data bit of 1 selects an active-high pin and 0 an active-low pin.
- R8: In edge mode a data bit of 1 selects rising and 0 falling edges. A detected edge sets the pin's sticky flag, and the request follows the flag. Edges of the other polarity, and edges on pins not in edge mode, set no flag.
- R9: Writing 1 to a bit of the flag register clears that flag and writing 0 leaves it. When an edge and a clear arrive in the same cycle, the edge wins.
- R10: Any write to the data register, or to the mode register holding a pin, restarts that pin's level qualification count.
- R11: The combined request is the OR of all per-pin requests.
- R12: Register addresses: 0 data, 1 modes of pins 0-3 (pin i at bits 2i+1:2i), 2 modes of pins 4-7, 3 synchronised input, 4 edge flags; other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Pad input values |
| pin_o | output | 8 | Pad output values (data register) |
| pin_oe_o | output | 8 | Pad output enables |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 8 | Per-pin interrupt requests |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The hardest cases to reach are the one-sample glitch and the restart of the qualification count. The glitch needs a pin pulse exactly one clock wide. The restart needs a register write that lands while a request is already active. The stimulus holds a level-mode pin at its active level until the request is up, then rewrites the same data value, which must drop the request for two clocks. Separately it toggles the pin for a single clock period and watches that no request appears. A behavioural model in the bench tracks the synchroniser, counters and flags and is compared with every output on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        PM_OUT  = 2'b00,
        PM_IN   = 2'b01,
        PM_LVL  = 2'b10,
        PM_EDGE = 2'b11
    } pin_mode_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_INPUT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG    = 3'd4;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] smp_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign smp_o  = st_q.s2;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [N_PINS-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    input  logic [N_PINS-1:0]     smp_i,
    input  logic [N_PINS-1:0]     flag_i,
    output logic [N_PINS-1:0]     data_o,
    output logic [2*N_PINS-1:0]   mode_o,
    output logic [N_PINS-1:0]     clr_cnt_o,
    output logic [N_PINS-1:0]     flag_clr_o,
    output logic [N_PINS-1:0]     rd_data_o
);

    localparam int HALF = N_PINS / 2;

    typedef struct packed {
        logic [N_PINS-1:0]   data;
        logic [2*N_PINS-1:0] mode;
    } regs_t;

    regs_t st_d, st_q;

    logic wr_data_hit, wr_lo_hit, wr_hi_hit;

    always_comb begin
        wr_data_hit = wr_en_i && (wr_addr_i == A_DATA);
        wr_lo_hit   = wr_en_i && (wr_addr_i == A_MODE_LO);
        wr_hi_hit   = wr_en_i && (wr_addr_i == A_MODE_HI);

        st_d = st_q;
        if (wr_data_hit) st_d.data = wr_data_i;
        if (wr_lo_hit)   st_d.mode[N_PINS-1:0] = wr_data_i;
        if (wr_hi_hit)   st_d.mode[2*N_PINS-1:N_PINS] = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.data <= '0;
            st_q.mode <= {N_PINS{PM_IN}};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_clr
        if (g < HALF) begin : g_lo
            assign clr_cnt_o[g] = wr_data_hit || wr_lo_hit;
        end else begin : g_hi
            assign clr_cnt_o[g] = wr_data_hit || wr_hi_hit;
        end
    end

    always_comb begin
        flag_clr_o = '0;
        if (wr_en_i && (wr_addr_i == A_FLAG)) flag_clr_o = wr_data_i;
    end

    always_comb begin
        unique case (rd_addr_i)
            A_DATA:    rd_data_o = st_q.data;
            A_MODE_LO: rd_data_o = st_q.mode[N_PINS-1:0];
            A_MODE_HI: rd_data_o = st_q.mode[2*N_PINS-1:N_PINS];
            A_INPUT:   rd_data_o = smp_i;
            A_FLAG:    rd_data_o = flag_i;
            default:   rd_data_o = '0;
        endcase
    end

    assign data_o = st_q.data;
    assign mode_o = st_q.mode;

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter int QUAL = 2
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  pin_mode_e mode_i,
    input  logic      data_i,
    input  logic      smp_i,
    input  logic      prev_i,
    input  logic      clr_cnt_i,
    input  logic      flag_clr_i,
    output logic      irq_o,
    output logic      flag_o,
    output logic      oe_o
);

    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] CMAX = CW'(QUAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } pin_t;

    pin_t st_d, st_q;

    logic match, edge_hit;

    always_comb begin
        match    = (mode_i == PM_LVL) && (smp_i == data_i);
        edge_hit = (mode_i == PM_EDGE) &&
                   (data_i ? (smp_i && !prev_i) : (!smp_i && prev_i));

        st_d = st_q;
        if (clr_cnt_i || !match)  st_d.cnt = '0;
        else if (st_q.cnt != CMAX) st_d.cnt = st_q.cnt + 1'b1;

        if (edge_hit)        st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o  = ((mode_i == PM_LVL) && (st_q.cnt == CMAX)) ||
                    ((mode_i == PM_EDGE) && st_q.flag);
    assign flag_o = st_q.flag;
    assign oe_o   = (mode_i == PM_OUT);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int QUAL_CYCLES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N_PINS-1:0]    pin_i,
    output logic [N_PINS-1:0]    pin_o,
    output logic [N_PINS-1:0]    pin_oe_o,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [N_PINS-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [N_PINS-1:0]    rd_data_o,
    output logic [N_PINS-1:0]    irq_o,
    output logic                 irq_any_o
);

    logic [N_PINS-1:0]   smp_w, prev_w, data_w, flag_w, clr_w, fclr_w;
    logic [2*N_PINS-1:0] mode_w;

    gpio_irq_sync #(.W(N_PINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .smp_o  (smp_w),
        .prev_o (prev_w)
    );

    gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .smp_i      (smp_w),
        .flag_i     (flag_w),
        .data_o     (data_w),
        .mode_o     (mode_w),
        .clr_cnt_o  (clr_w),
        .flag_clr_o (fclr_w),
        .rd_data_o  (rd_data_o)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_irq_pin #(.QUAL(QUAL_CYCLES)) u_pin (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .mode_i     (pin_mode_e'(mode_w[2*g +: 2])),
            .data_i     (data_w[g]),
            .smp_i      (smp_w[g]),
            .prev_i     (prev_w[g]),
            .clr_cnt_i  (clr_w[g]),
            .flag_clr_i (fclr_w[g]),
            .irq_o      (irq_o[g]),
            .flag_o     (flag_w[g]),
            .oe_o       (pin_oe_o[g])
        );
    end

    assign pin_o = data_w;

    always_comb begin
        irq_any_o = 1'b0;
        for (int i = 0; i < N_PINS; i++) irq_any_o = irq_any_o | irq_o[i];
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [N_PINS-1:0]    pin_i,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    wr_addr_i,
    input logic [N_PINS-1:0]    wr_data_i,
    input logic [ADDR_W-1:0]    rd_addr_i,
    input logic [N_PINS-1:0]    rd_data_i,
    input logic [N_PINS-1:0]    irq_i,
    input logic [2*N_PINS-1:0]  mode_i,
    input logic [N_PINS-1:0]    data_i,
    input logic [N_PINS-1:0]    smp_i,
    input logic [N_PINS-1:0]    flag_i
);

    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R3
    input_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == A_INPUT && age_q >= 2'd2) |-> rd_data_i == $past(pin_i, 2));

    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        // R4
        lvl_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[2*g +: 2] == PM_LVL && irq_i[g]) |-> $past(smp_i[g]) == data_i[g]);

        // R6
        lvl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[2*g +: 2] == PM_LVL && $past(smp_i[g]) != $past(data_i[g])) |-> !irq_i[g]);

        // R8
        flag_edge_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flag_i[g]) |-> $past(mode_i[2*g +: 2]) == PM_EDGE);

        // R9
        flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flag_i[g]) |-> $past(wr_en_i && wr_addr_i == A_FLAG && wr_data_i[g]));
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_i (rd_data_o),
    .irq_i     (irq_o),
    .mode_i    (mode_w),
    .data_i    (data_w),
    .smp_i     (smp_w),
    .flag_i    (flag_w)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = 8'h00;
    logic [7:0] pin_o, oe_o, rd_data, irq;
    logic       irq_any;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_port u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pin_i     (pin),
        .pin_o     (pin_o),
        .pin_oe_o  (oe_o),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .irq_any_o (irq_any)
    );

    // behavioural reference model
    bit [7:0]  m_s1, m_s2, m_prev, m_data, m_flag;
    bit [15:0] m_mode;
    int        m_cnt [8];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_data = 0; m_flag = 0;
            m_mode = 16'h5555;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            bit [7:0] nflag;
            nflag = m_flag;
            for (int i = 0; i < 8; i++) begin
                int  md;
                bit  clr, rise, fall;
                md   = m_mode[2*i +: 2];
                clr  = wr_en && (wr_addr == 0 || (wr_addr == 1 && i < 4) || (wr_addr == 2 && i >= 4));
                if (clr || md != 2 || m_s2[i] != m_data[i]) m_cnt[i] = 0;
                else if (m_cnt[i] < 2) m_cnt[i] = m_cnt[i] + 1;
                rise = m_s2[i] && !m_prev[i];
                fall = !m_s2[i] && m_prev[i];
                if (md == 3 && (m_data[i] ? rise : fall)) nflag[i] = 1;
                else if (wr_en && wr_addr == 4 && wr_data[i]) nflag[i] = 0;
            end
            m_flag = nflag;
            if (wr_en && wr_addr == 0) m_data = wr_data;
            if (wr_en && wr_addr == 1) m_mode[7:0] = wr_data;
            if (wr_en && wr_addr == 2) m_mode[15:8] = wr_data;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin;
        end
    end

    function automatic bit [7:0] exp_irq();
        bit [7:0] r = 0;
        for (int i = 0; i < 8; i++) begin
            int md = m_mode[2*i +: 2];
            r[i] = (md == 2 && m_cnt[i] >= 2) || (md == 3 && m_flag[i]);
        end
        return r;
    endfunction

    function automatic bit [7:0] exp_oe();
        bit [7:0] r = 0;
        for (int i = 0; i < 8; i++) r[i] = (m_mode[2*i +: 2] == 0);
        return r;
    endfunction

    function automatic bit [7:0] exp_rd();
        case (rd_addr)
            3'd0: return m_data;
            3'd1: return m_mode[7:0];
            3'd2: return m_mode[15:8];
            3'd3: return m_s2;
            3'd4: return m_flag;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 oe", oe_o, exp_oe());
        chk("R2 out", pin_o, m_data);
        chk("R4 irq model", irq, exp_irq());
        chk("R11 irq_any", {7'd0, irq_any}, {7'd0, |exp_irq()});
        chk("R12 read", rd_data, exp_rd());
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #4;
            if (rst_n) compare();
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 oe", oe_o, 8'h00);
        chk("R1 irq", irq, 8'h00);
        rd_addr = 3'd1; #1 chk("R1 mode lo", rd_data, 8'h55);
        rd_addr = 3'd2; #1 chk("R1 mode hi", rd_data, 8'h55);
        rd_addr = 3'd0; #1 chk("R1 data", rd_data, 8'h00);
        rd_addr = 3'd4; #1 chk("R1 flags", rd_data, 8'h00);
        rd_addr = 3'd7; #1 chk("R12 unused addr", rd_data, 8'h00);

        // R2 output mode
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        chk("R2 oe all", oe_o, 8'hFF);
        chk("R2 out", pin_o, 8'hA5);

        // R3 synchroniser delay
        rd_addr = 3'd3;
        pin = 8'h3C;
        tick();
        chk("R3 not yet", rd_data, 8'h00);
        tick();
        chk("R3 input", rd_data, 8'h3C);

        // R4 / R7 active-high level on pin 0
        wr(3'd1, 8'h56);
        wr(3'd2, 8'h55);
        wr(3'd0, 8'h01);
        chk("R2 level oe", oe_o, 8'h00);
        tick(3);
        pin = 8'h3D;
        tick(3);
        chk("R4 before qual", irq, 8'h00);
        tick();
        chk("R4 qualified", irq, 8'h01);
        chk("R11 any", {7'd0, irq_any}, 8'h01);

        // R6 release
        pin = 8'h3C;
        tick(2);
        chk("R6 still held", irq, 8'h01);
        tick();
        chk("R6 released", irq, 8'h00);

        // R5 one-clock glitch
        tick(3);
        pin = 8'h3D;
        tick();
        pin = 8'h3C;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R5 glitch", irq, 8'h00);
        end

        // R7 active-low level
        wr(3'd0, 8'h00);
        tick(2);
        chk("R7 low level", irq, 8'h01);

        // R10 rewrite restarts qualification
        wr(3'd0, 8'h00);
        chk("R10 restart", irq, 8'h00);
        tick(2);
        chk("R10 requalified", irq, 8'h01);

        // R8 rising edge on pin 1
        wr(3'd1, 8'h5D);
        wr(3'd0, 8'h02);
        tick(3);
        rd_addr = 3'd4;
        pin = 8'h3E;
        tick(2);
        chk("R8 edge pending", irq, 8'h00);
        tick();
        chk("R8 rise irq", irq, 8'h02);
        chk("R8 rise flag", rd_data, 8'h02);
        pin = 8'h3C;
        tick(4);
        chk("R8 sticky", rd_data, 8'h02);

        // R9 write-one-to-clear
        wr(3'd4, 8'h00);
        chk("R9 zero ignored", rd_data, 8'h02);
        wr(3'd4, 8'h02);
        chk("R9 cleared", rd_data, 8'h00);
        chk("R9 irq cleared", irq, 8'h00);

        // R8 falling select ignores rising edge
        wr(3'd0, 8'h00);
        pin = 8'h3E;
        tick(4);
        chk("R8 rise ignored", rd_data, 8'h00);
        pin = 8'h3C;
        tick(2);
        chk("R8 fall pending", rd_data, 8'h00);
        tick();
        chk("R8 fall flag", rd_data, 8'h02);

        // R8 input-mode pin toggles set nothing
        pin = 8'h7C;
        tick(4);
        pin = 8'h3C;
        tick(4);
        chk("R8 input no flag", rd_data, 8'h02);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule